// File: doc/BRIEF.md
# Transmit Deinterleaver and DAC Router

The block takes a host stream of 16-bit words in which the real and imaginary parts of one or two complex transmit channels are interleaved. It gathers one complete sample period worth of words into a staging buffer and, when the sample-rate strobe fires, moves that set into the sample registers all at once. Those registers hold the I and Q values of two interpolator channels.

Each of four DAC outputs picks any one of the four interpolator values, or stays off. The choice comes from its own 4-bit field in a single configuration word. Within a field, the top bit turns the output on and the lower three bits pick the source. If the strobe arrives before a full set has been collected, the sample registers keep their old values and an underrun flag is raised until the next strobe that finds a full set. The input stream uses valid/ready flow control, and ready stays low while a complete set waits for the strobe.

Top module: `tx_dac_router`

## Requirements
- R1: During and right after reset, in_ready_o is 1, underrun_o is 0 and every sample register is zero, so every dac_data_o lane reads zero.
- R2: With cfg_i[3:0] = 2, the four accepted words of a set are assigned in arrival order to source 0 (channel 0 I), source 1 (channel 0 Q), source 2 (channel 1 I) and source 3 (channel 1 Q).
- R3: With cfg_i[3:0] = 1, two accepted words make a set and fill sources 0 and 1. Sources 2 and 3 become zero at the strobe.
- R4: Once the last word of a set is accepted, in_ready_o is 0 from the next cycle. It stays 0 until a strobe takes the set, and returns to 1 in the cycle after that strobe.
- R5: The sample registers change only in the cycle after a strobe_i that finds a complete set. Words that are accepted do not reach the DAC outputs before that strobe.
- R6: A strobe that finds no complete set leaves the sample registers unchanged and sets underrun_o to 1 from the next cycle. A strobe that finds a complete set clears underrun_o. Without a strobe, underrun_o holds its value.
- R7: DAC k is controlled by field cfg_i[4k+7:4k+4]. Bit 3 of the field is the enable, and bits 2:0 pick the source 0..3 as defined in R2. With the enable set and a source of 3 or less, dac_en_o[k] is 1 and lane k of dac_data_o (bits 16k+15:16k) carries the selected value. Routing follows cfg_i combinationally.
- R8: A DAC whose enable bit is 0, or whose source value is 4 to 7, drives zero data with dac_en_o[k] = 0.
- R9: A strobe that underruns keeps the words already collected. The set is completed by the words that follow and is presented on a later strobe.
- R10: Any cfg_i[3:0] code other than 2, including codes with the reserved bit 3 set, behaves as the single-channel mode of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 20 | Channel count code [3:0], then four 4-bit DAC fields |
| in_data_i | input | 16 | Interleaved host word |
| in_valid_i | input | 1 | Host word valid |
| in_ready_o | output | 1 | Block can accept a word |
| strobe_i | input | 1 | Sample-rate strobe, one cycle per sample period |
| dac_data_o | output | 64 | Four 16-bit DAC lanes, lane k at bits 16k+15:16k |
| dac_en_o | output | 4 | Per-DAC enable |
| underrun_o | output | 1 | Last strobe found no complete set |

## Verification
The bench aims at the strobe that lands on a half-collected set. A design that reset its word counter there would misalign I and Q for all later samples. A design that presented the partial set would show stale words on channel 1. A strobe arriving in the same cycle as the last word is also tested, since it must still count as an underrun, and ready must reopen only after the set is taken; a block that ignored this would drop or overwrite words. Routing is checked with permuted, disabled and out-of-range source fields, where a decoder that only looked at the low two select bits would wrongly drive an output. The single-channel and illegal count codes are checked to zero channel 1 and to close a set after two words.

// File: rtl/tx_router_pkg.sv
package tx_router_pkg;
  localparam int NCH_W   = 4;   // count code incl. reserved bit
  localparam int SEL_W   = 3;
  localparam int FIELD_W = SEL_W + 1;
  localparam logic [NCH_W-1:0] NCH_DUAL = 4'd2;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
  } dac_field_t;
endpackage

// File: rtl/tx_word_collector.sv
module tx_word_collector #(
  parameter int DATA_W  = 16,
  parameter int NUM_SRC = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      dual_i,
  input  logic [DATA_W-1:0]         data_i,
  input  logic                      valid_i,
  output logic                      ready_o,
  input  logic                      strobe_i,
  output logic [NUM_SRC*DATA_W-1:0] sample_o,
  output logic                      underrun_o
);
  localparam int IDX_W = $clog2(NUM_SRC);
  localparam int HALF  = NUM_SRC / 2;

  logic [DATA_W-1:0] stage_q  [NUM_SRC];
  logic [DATA_W-1:0] sample_q [NUM_SRC];
  logic [IDX_W-1:0]  idx_q, last_idx;
  logic              full_q, underrun_q, accept, take;

  assign last_idx = dual_i ? IDX_W'(NUM_SRC - 1) : IDX_W'(HALF - 1);
  assign accept   = valid_i && !full_q;
  assign take     = strobe_i && full_q;
  assign ready_o  = !full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      full_q <= 1'b0;
    end else begin
      if (take) full_q <= 1'b0;
      if (accept) begin
        if (idx_q == last_idx) begin
          idx_q  <= '0;
          full_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       underrun_q <= 1'b0;
    else if (strobe_i) underrun_q <= !full_q;
  end
  assign underrun_o = underrun_q;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_slot
    localparam bit UPPER = (k >= HALF);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             stage_q[k] <= '0;
      else if (accept && idx_q == IDX_W'(k))   stage_q[k] <= data_i;
    end

    // upper channel is blanked in single-channel mode
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   sample_q[k] <= '0;
      else if (take) sample_q[k] <= (UPPER && !dual_i) ? '0 : stage_q[k];
    end

    assign sample_o[k*DATA_W +: DATA_W] = sample_q[k];
  end
endmodule

// File: rtl/tx_dac_select.sv
module tx_dac_select
  import tx_router_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int NUM_SRC = 4
) (
  input  dac_field_t                field_i,
  input  logic [NUM_SRC*DATA_W-1:0] sample_i,
  output logic [DATA_W-1:0]         data_o,
  output logic                      en_o
);
  localparam int SRC_W = $clog2(NUM_SRC);

  logic             in_range;
  logic [SRC_W-1:0] idx;

  assign in_range = int'(field_i.sel) < NUM_SRC;
  assign idx      = field_i.sel[SRC_W-1:0];
  assign en_o     = field_i.en && in_range;
  assign data_o   = en_o ? sample_i[int'(idx)*DATA_W +: DATA_W] : '0;
endmodule

// File: rtl/tx_dac_router.sv
module tx_dac_router
  import tx_router_pkg::*;
#(
  parameter  int DATA_W  = 16,
  parameter  int NUM_DAC = 4,
  localparam int NUM_CH  = 2,
  localparam int NUM_SRC = 2 * NUM_CH,
  localparam int CFG_W   = NCH_W + FIELD_W * NUM_DAC
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [CFG_W-1:0]          cfg_i,
  input  logic [DATA_W-1:0]         in_data_i,
  input  logic                      in_valid_i,
  output logic                      in_ready_o,
  input  logic                      strobe_i,
  output logic [NUM_DAC*DATA_W-1:0] dac_data_o,
  output logic [NUM_DAC-1:0]        dac_en_o,
  output logic                      underrun_o
);
  logic                      dual;
  logic [NUM_SRC*DATA_W-1:0] sample_flat;

  assign dual = (cfg_i[NCH_W-1:0] == NCH_DUAL);

  tx_word_collector #(
    .DATA_W (DATA_W),
    .NUM_SRC(NUM_SRC)
  ) u_collector (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dual_i    (dual),
    .data_i    (in_data_i),
    .valid_i   (in_valid_i),
    .ready_o   (in_ready_o),
    .strobe_i  (strobe_i),
    .sample_o  (sample_flat),
    .underrun_o(underrun_o)
  );

  for (genvar k = 0; k < NUM_DAC; k++) begin : g_dac
    dac_field_t fld;
    assign fld = dac_field_t'(cfg_i[NCH_W + k*FIELD_W +: FIELD_W]);

    tx_dac_select #(
      .DATA_W (DATA_W),
      .NUM_SRC(NUM_SRC)
    ) u_select (
      .field_i (fld),
      .sample_i(sample_flat),
      .data_o  (dac_data_o[k*DATA_W +: DATA_W]),
      .en_o    (dac_en_o[k])
    );
  end
endmodule

// File: rtl/tx_dac_router_checker.sv
module tx_dac_router_checker
  import tx_router_pkg::*;
#(
  parameter  int DATA_W  = 16,
  parameter  int NUM_DAC = 4,
  localparam int NUM_SRC = 4,
  localparam int HALF_W  = (NUM_SRC / 2) * DATA_W,
  localparam int CFG_W   = NCH_W + FIELD_W * NUM_DAC
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [CFG_W-1:0]          cfg_i,
  input logic                      strobe_i,
  input logic                      in_ready_o,
  input logic                      underrun_o,
  input logic [NUM_DAC*DATA_W-1:0] dac_data_o,
  input logic [NUM_DAC-1:0]        dac_en_o,
  input logic [NUM_SRC*DATA_W-1:0] sample_i
);
  assert_ready_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_ready_o && !strobe_i) |=> !in_ready_o);

  assert_ready_reopen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_ready_o && strobe_i) |=> (in_ready_o && !underrun_o));

  assert_sample_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(sample_i));

  assert_underrun_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && in_ready_o) |=> (underrun_o && $stable(sample_i)));

  assert_underrun_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(underrun_o));

  assert_single_blank_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !in_ready_o && cfg_i[NCH_W-1:0] != NCH_DUAL) |=>
      (sample_i[NUM_SRC*DATA_W-1:HALF_W] == '0));

  for (genvar k = 0; k < NUM_DAC; k++) begin : g_chk
    dac_field_t fld;
    assign fld = dac_field_t'(cfg_i[NCH_W + k*FIELD_W +: FIELD_W]);

    assert_dac_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !dac_en_o[k] |-> (dac_data_o[k*DATA_W +: DATA_W] == '0));

    assert_en_field_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dac_en_o[k] |-> (fld.en && int'(fld.sel) < NUM_SRC));

    assert_route_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dac_en_o[k] |-> (dac_data_o[k*DATA_W +: DATA_W] ==
                       sample_i[int'(fld.sel[1:0])*DATA_W +: DATA_W]));
  end
endmodule

bind tx_dac_router tx_dac_router_checker #(
  .DATA_W (DATA_W),
  .NUM_DAC(NUM_DAC)
) u_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cfg_i     (cfg_i),
  .strobe_i  (strobe_i),
  .in_ready_o(in_ready_o),
  .underrun_o(underrun_o),
  .dac_data_o(dac_data_o),
  .dac_en_o  (dac_en_o),
  .sample_i  (sample_flat)
);

// File: tb/tx_dac_router_bench.sv
`timescale 1ns/1ps
module tx_dac_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] cfg = 20'hBA982;
  logic [15:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        strobe = 1'b0;
  logic [63:0] dac_data;
  logic [3:0]  dac_en;
  logic        underrun;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tx_dac_router u_tx_dac_router (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .cfg_i     (cfg),
    .in_data_i (in_data),
    .in_valid_i(in_valid),
    .in_ready_o(in_ready),
    .strobe_i  (strobe),
    .dac_data_o(dac_data),
    .dac_en_o  (dac_en),
    .underrun_o(underrun)
  );

  // behavioural reference
  logic [15:0] ref_buf[$];
  logic [15:0] ref_pres[4];
  bit          ref_full, ref_under, m_acc, m_dual;
  int          m_need;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_buf.delete();
      ref_full  = 1'b0;
      ref_under = 1'b0;
      for (int k = 0; k < 4; k++) ref_pres[k] = '0;
    end else begin
      m_acc  = in_valid && !ref_full;
      m_dual = (cfg[3:0] == 4'd2);
      m_need = m_dual ? 4 : 2;
      if (strobe) begin
        if (ref_full) begin
          for (int k = 0; k < 4; k++)
            ref_pres[k] = (k < 2 || m_dual) ? ref_buf[k] : 16'h0;
          ref_buf.delete();
          ref_full  = 1'b0;
          ref_under = 1'b0;
        end else begin
          ref_under = 1'b1;
        end
      end
      if (m_acc) begin
        ref_buf.push_back(in_data);
        if (ref_buf.size() == m_need) ref_full = 1'b1;
      end
    end
  end

  function automatic logic [15:0] exp_lane(int k);
    logic [3:0] f = cfg[4 + 4*k +: 4];
    if (f[3] && f[2:0] < 3'd4) return ref_pres[f[1:0]];
    return 16'h0;
  endfunction

  function automatic logic exp_en(int k);
    logic [3:0] f = cfg[4 + 4*k +: 4];
    return f[3] && (f[2:0] < 3'd4);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R4 ready", 32'(in_ready), 32'(!ref_full));
      chk("R6 underrun", 32'(underrun), 32'(ref_under));
      for (int k = 0; k < 4; k++) begin
        chk("R2/R3/R7/R8 lane", 32'(dac_data[16*k +: 16]), 32'(exp_lane(k)));
        chk("R7/R8 enable", 32'(dac_en[k]), 32'(exp_en(k)));
      end
    end
  end

  task automatic send(input logic [15:0] w);
    bit ok;
    in_valid = 1'b1;
    in_data  = w;
    do begin
      ok = in_ready;
      @(negedge clk);
    end while (!ok);
    in_valid = 1'b0;
  endtask

  task automatic pulse;
    strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
  endtask

  function automatic logic [15:0] lane(int k);
    return dac_data[16*k +: 16];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 state held in reset
    chk("R1 ready in reset", 32'(in_ready), 32'd1);
    chk("R1 lanes in reset", 32'(dac_data[31:0] | dac_data[63:32]), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 ready", 32'(in_ready), 32'd1);
    chk("R1 underrun", 32'(underrun), 32'd0);
    chk("R1 lane0", 32'(lane(0)), 32'd0);
    @(negedge clk);

    // R2 dual-channel order, R4/R5 before strobe
    send(16'h1111); send(16'h2222); send(16'h3333); send(16'h4444);
    #1;
    chk("R4 ready low when full", 32'(in_ready), 32'd0);
    chk("R5 no output before strobe", 32'(lane(0)), 32'd0);
    @(negedge clk);
    pulse();
    #1;
    chk("R2 lane0 ch0 I", 32'(lane(0)), 32'h1111);
    chk("R2 lane1 ch0 Q", 32'(lane(1)), 32'h2222);
    chk("R2 lane2 ch1 I", 32'(lane(2)), 32'h3333);
    chk("R2 lane3 ch1 Q", 32'(lane(3)), 32'h4444);
    chk("R4 ready after take", 32'(in_ready), 32'd1);
    @(negedge clk);

    // R6 empty strobe
    pulse();
    #1;
    chk("R6 underrun set", 32'(underrun), 32'd1);
    chk("R6 lane0 held", 32'(lane(0)), 32'h1111);
    @(negedge clk);

    // R9 partial set survives an underrun strobe
    send(16'h5555); send(16'h6666);
    pulse();
    #1;
    chk("R9 held on partial", 32'(lane(0)), 32'h1111);
    chk("R9 underrun on partial", 32'(underrun), 32'd1);
    @(negedge clk);
    send(16'h7777); send(16'h8888);
    pulse();
    #1;
    chk("R9 lane0 completed", 32'(lane(0)), 32'h5555);
    chk("R9 lane3 completed", 32'(lane(3)), 32'h8888);
    chk("R6 underrun cleared", 32'(underrun), 32'd0);
    @(negedge clk);

    // R7 permuted, R8 disabled and out-of-range select
    cfg = 20'h8D0B2;
    #1;
    chk("R7 lane0 sel3", 32'(lane(0)), 32'h8888);
    chk("R8 lane1 disabled", 32'({dac_en[1], lane(1)}), 32'd0);
    chk("R8 lane2 sel5", 32'({dac_en[2], lane(2)}), 32'd0);
    chk("R7 lane3 sel0", 32'(lane(3)), 32'h5555);
    @(negedge clk);

    // R3 single-channel
    cfg = 20'hBA981;
    send(16'h9999); send(16'hAAAA);
    #1;
    chk("R3 ready low after two", 32'(in_ready), 32'd0);
    @(negedge clk);
    pulse();
    #1;
    chk("R3 lane0", 32'(lane(0)), 32'h9999);
    chk("R3 lane1", 32'(lane(1)), 32'hAAAA);
    chk("R3 lane2 zero", 32'(lane(2)), 32'd0);
    chk("R3 lane3 enabled", 32'(dac_en[3]), 32'd1);
    @(negedge clk);

    // R10 reserved bit set
    cfg = 20'hBA98A;
    send(16'h1234); send(16'h5678);
    #1;
    chk("R10 ready low after two", 32'(in_ready), 32'd0);
    @(negedge clk);
    pulse();
    #1;
    chk("R10 lane2 zero", 32'(lane(2)), 32'd0);
    chk("R10 lane1", 32'(lane(1)), 32'h5678);
    @(negedge clk);

    // continuous stream with free-running strobes, model compared every cycle
    cfg = 20'hBA982;
    fork
      for (int i = 0; i < 28; i++) send(16'(16'hC000 + i * 16'h0101));
      repeat (14) begin
        repeat (3 + ($time % 3)) @(negedge clk);
        pulse();
      end
    join
    repeat (2) begin @(negedge clk); pulse(); end
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule